// File: doc/BRIEF.md
# Bidirectional Port with External Address Takeover

This block is an eight-pin general-purpose I/O port that sits on a microcontroller peripheral bus. Software writes an output latch and a direction register. Each direction bit chooses, for its own pin, whether the pin drives the latched level or is left floating so that its level can be read. One bit in a separate pull-up register turns on the weak pull-ups of every pin that is currently an input. Pin levels pass through a two-stage synchronizer before any read can see them.

When the chip runs with external memory attached, the port gives up its pins. They then carry the upper byte of the external address. A three-bit expansion-mode register field and an external-access input decide which of the two roles the port has. In the address role, every pin drives. The latch, direction and pull-up settings are kept unchanged and come back into force when the port returns to normal I/O.

The register interface uses a two-bit address, a write strobe, a read strobe and byte-wide data buses. Writes take effect on the clock edge. Read data is combinational while the read strobe is high.

Top module: `gpio_xbus_port`

## Requirements
- R1: When reset is released, every `pin_oe` and `pin_pu` bit is 0 and the direction, pull-up and expansion-mode registers read as 0. The output latch value after reset is not defined.
- R2: A write to address 0 stores `bus_wdata` in the output latch. In normal I/O mode, `pin_out` shows the latch on the cycle after the write edge.
- R3: In normal I/O mode, `pin_oe[i]` equals direction bit i (1 = output). The direction register is loaded by a full-byte write to address 1.
- R4: A read of address 1 always returns 0. The direction register cannot be read back.
- R5: A read of address 0 returns, for each bit, the synchronized pin level when its direction bit is 0 and the latch bit when its direction bit is 1.
- R6: A change on `pin_in` is not visible to a read after one rising clock edge. It becomes visible after the second rising edge.
- R7: Bit 0 of address 2 is the port-wide pull-up enable. `pin_pu[i]` is 1 only when that bit is 1, pin i is an input, and the port is in normal I/O mode.
- R8: The port is in address mode when `ext_access` is 1 or when the expansion field (address 3, bits 2:0) is not 000. In address mode all `pin_oe` bits are 1 and `pin_out` equals `xaddr_hi`, whatever the direction bits say.
- R9: When the port leaves address mode, the latch and direction values written earlier are in force again.
- R10: A read of address 2 returns the pull-up enable in bit 0 with 0 in bits 7:1. A read of address 3 returns the expansion field in bits 2:0 with 0 above.
- R11: Without `bus_wr`, no register changes. While `bus_rd` is 0, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| ext_access | input | 1 | Forces address mode when high |
| xaddr_hi | input | 8 | Upper address byte driven in address mode |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables |
| pin_pu | output | 8 | Pin pull-up enables |

## Verification
A wrong direction bit shows up on `pin_oe` in the cycle after the write, and in the mix of latch and pin bits in a port read. A wrong expansion field shows up at once as all-ones enables and the address byte on the pins. Synchronizer faults show as a read that is one cycle early or late after a pin edge. Because the direction register reads as zero, its state can only be seen through `pin_oe`, `pin_pu` and port reads, so every direction check goes through those ports.

// File: rtl/gpio_xbus_pkg.sv
package gpio_xbus_pkg;

    localparam int PORT_W  = 8;
    localparam int MODE_W  = 3;
    localparam int ADDR_W  = 2;
    localparam int PULL_BIT = 0;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LATCH = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_PULL  = 2'd2,
        SEL_XMODE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [MODE_W-1:0] xmode;
        logic              pull_en;
    } ctrl_t;

    function automatic logic addr_role(input logic [MODE_W-1:0] xmode,
                                       input logic ext);
        return ext || (xmode != '0);
    endfunction

endpackage

// File: rtl/gpio_xbus_sync.sv
module gpio_xbus_sync #(
    parameter int W = gpio_xbus_pkg::PORT_W
) (
    input  logic         clk,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic hold_q;
        always_ff @(posedge clk) begin
            meta_q <= raw[i];
            hold_q <= meta_q;
        end
        assign synced[i] = hold_q;
    end
endmodule

// File: rtl/gpio_xbus_regs.sv
module gpio_xbus_regs
    import gpio_xbus_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pins_sync,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      dir_q,
    output ctrl_t             ctrl_q
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    // Output latch: deliberately not reset (value undefined after reset)
    always_ff @(posedge clk) begin
        if (wr && sel == SEL_LATCH) latch_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            ctrl_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_DIR:   dir_q         <= wdata;
                SEL_PULL:  ctrl_q.pull_en <= wdata[PULL_BIT];
                SEL_XMODE: ctrl_q.xmode  <= wdata[MODE_W-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                SEL_LATCH: rdata = (pins_sync & ~dir_q) | (latch_q & dir_q);
                SEL_DIR:   rdata = '0;
                SEL_PULL:  rdata[PULL_BIT] = ctrl_q.pull_en;
                SEL_XMODE: rdata[MODE_W-1:0] = ctrl_q.xmode;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_xbus_padmux.sv
module gpio_xbus_padmux #(
    parameter int W = gpio_xbus_pkg::PORT_W
) (
    input  logic         addr_mode,
    input  logic         pull_en,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] addr_byte,
    output logic [W-1:0] out,
    output logic [W-1:0] oe,
    output logic [W-1:0] pu
);
    for (genvar i = 0; i < W; i++) begin : g_pad
        assign out[i] = addr_mode ? addr_byte[i] : latch[i];
        assign oe[i]  = addr_mode | dir[i];
        assign pu[i]  = pull_en & ~addr_mode & ~dir[i];
    end
endmodule

// File: rtl/gpio_xbus_port.sv
module gpio_xbus_port
    import gpio_xbus_pkg::*;
#(
    parameter int PORT_WIDTH = PORT_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [PORT_WIDTH-1:0] bus_wdata,
    output logic [PORT_WIDTH-1:0] bus_rdata,
    input  logic                  ext_access,
    input  logic [PORT_WIDTH-1:0] xaddr_hi,
    input  logic [PORT_WIDTH-1:0] pin_in,
    output logic [PORT_WIDTH-1:0] pin_out,
    output logic [PORT_WIDTH-1:0] pin_oe,
    output logic [PORT_WIDTH-1:0] pin_pu
);
    logic [PORT_WIDTH-1:0] pins_sync;
    logic [PORT_WIDTH-1:0] latch_q;
    logic [PORT_WIDTH-1:0] dir_q;
    ctrl_t                 ctrl_q;
    logic                  addr_mode;

    gpio_xbus_sync #(.W(PORT_WIDTH)) u_sync (
        .clk    (clk),
        .raw    (pin_in),
        .synced (pins_sync)
    );

    gpio_xbus_regs #(.W(PORT_WIDTH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .wdata     (bus_wdata),
        .pins_sync (pins_sync),
        .rdata     (bus_rdata),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .ctrl_q    (ctrl_q)
    );

    assign addr_mode = addr_role(ctrl_q.xmode, ext_access);

    gpio_xbus_padmux #(.W(PORT_WIDTH)) u_pads (
        .addr_mode (addr_mode),
        .pull_en   (ctrl_q.pull_en),
        .latch     (latch_q),
        .dir       (dir_q),
        .addr_byte (xaddr_hi),
        .out       (pin_out),
        .oe        (pin_oe),
        .pu        (pin_pu)
    );
endmodule

// File: rtl/gpio_xbus_port_chk.sv
module gpio_xbus_port_chk #(
    parameter int W = gpio_xbus_pkg::PORT_W
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   bus_addr,
    input logic         bus_wr,
    input logic         bus_rd,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic         ext_access,
    input logic [W-1:0] xaddr_hi,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] pin_pu,
    input logic [W-1:0] dir,
    input logic [2:0]   xmode
);
    logic bus_now;
    assign bus_now = ext_access || (xmode != 3'd0);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0 && pin_pu == '0));

    a_r2_latch_visible: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> (bus_now || pin_out == $past(bus_wdata)));

    a_r3_dir_drives_oe: assert property (@(posedge clk) disable iff (rst)
        !bus_now |-> (pin_oe == dir));

    a_r4_dir_unreadable: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd1) |-> (bus_rdata == '0));

    a_r6_sync_latency: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd0) |-> ((bus_rdata & ~dir) == ($past(pin_in, 2) & ~dir)));

    a_r7_pull_only_inputs: assert property (@(posedge clk) disable iff (rst)
        (pin_pu & pin_oe) == '0);

    a_r8_addr_takeover: assert property (@(posedge clk) disable iff (rst)
        bus_now |-> (pin_oe == '1 && pin_out == xaddr_hi));

    a_r11_idle_read: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind gpio_xbus_port gpio_xbus_port_chk #(.W(PORT_WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ext_access (ext_access),
    .xaddr_hi   (xaddr_hi),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .pin_pu     (pin_pu),
    .dir        (dir_q),
    .xmode      (ctrl_q.xmode)
);

// File: tb/gpio_xbus_port_tb.sv
module gpio_xbus_port_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_access = 1'b0;
    logic [7:0] xaddr_hi = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe, pin_pu;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_xbus_port u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_access(ext_access), .xaddr_hi(xaddr_hi), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    typedef struct packed {
        logic [7:0] dir;
        logic [7:0] lat;
        logic [7:0] pin;
        logic [7:0] hi;
        logic       pull;
        logic [2:0] xmode;
        logic       ext;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'hF0, 8'hA5, 8'h3C, 8'h00, 1'b1, 3'd0, 1'b0},
        '{8'h0F, 8'h5A, 8'hC3, 8'h11, 1'b0, 3'd0, 1'b0},
        '{8'hFF, 8'h81, 8'h00, 8'h22, 1'b1, 3'd0, 1'b0},
        '{8'h00, 8'h00, 8'hFF, 8'h33, 1'b1, 3'd0, 1'b0},
        '{8'h55, 8'hFF, 8'hAA, 8'hC6, 1'b1, 3'd0, 1'b1},
        '{8'h00, 8'h12, 8'h5A, 8'h9E, 1'b1, 3'd4, 1'b0},
        '{8'h3C, 8'h77, 8'h81, 8'h42, 1'b1, 3'd0, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        #1;
        check("R1 oe", pin_oe, 8'h00);
        check("R1 pu", pin_pu, 8'h00);
        rd(2'd1, d); check("R1 dir read", d, 8'h00);
        rd(2'd2, d); check("R1 pull read", d, 8'h00);
        rd(2'd3, d); check("R1 xmode read", d, 8'h00);

        // Table walk: R2 R3 R5 R7 R8 R9
        for (int k = 0; k < NV; k++) begin
            logic       bm;
            logic [7:0] e_oe, e_out, e_pu, e_rd;
            wr(2'd1, VECS[k].dir);
            wr(2'd0, VECS[k].lat);
            wr(2'd2, {7'b0, VECS[k].pull});
            wr(2'd3, {5'b0, VECS[k].xmode});
            ext_access = VECS[k].ext;
            pin_in     = VECS[k].pin;
            xaddr_hi   = VECS[k].hi;
            repeat (3) @(negedge clk);
            bm    = VECS[k].ext || (VECS[k].xmode != 3'd0);
            e_oe  = bm ? 8'hFF : VECS[k].dir;
            e_out = bm ? VECS[k].hi : VECS[k].lat;
            e_pu  = (VECS[k].pull && !bm) ? ~VECS[k].dir : 8'h00;
            e_rd  = (VECS[k].pin & ~VECS[k].dir) | (VECS[k].lat & VECS[k].dir);
            #1;
            check(bm ? "R8 oe" : "R3 oe", pin_oe, e_oe);
            check(bm ? "R8 out" : (k == NV-1 ? "R9 out" : "R2 out"), pin_out, e_out);
            check("R7 pu", pin_pu, e_pu);
            rd(2'd0, d); check("R5 port read", d, e_rd);
        end

        // R4: direction unreadable, yet in force
        ext_access = 1'b0;
        wr(2'd3, 8'h00);
        wr(2'd1, 8'hFF);
        rd(2'd1, d); check("R4 dir read", d, 8'h00);
        #1 check("R4 oe", pin_oe, 8'hFF);

        // R6: two-edge synchronizer latency
        wr(2'd1, 8'h00);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'hFF;
        @(negedge clk);
        bus_addr = 2'd0; bus_rd = 1'b1;
        #1 check("R6 after one edge", bus_rdata, 8'h00);
        bus_rd = 1'b0;
        @(negedge clk);
        bus_rd = 1'b1;
        #1 check("R6 after two edges", bus_rdata, 8'hFF);
        bus_rd = 1'b0;

        // R10: readback of pull and expansion field
        wr(2'd2, 8'hFF);
        rd(2'd2, d); check("R10 pull read", d, 8'h01);
        wr(2'd3, 8'hFF);
        rd(2'd3, d); check("R10 xmode read", d, 8'h07);
        #1 check("R8 field takeover oe", pin_oe, 8'hFF);
        wr(2'd3, 8'h00);

        // R11: no write without strobe, idle read is 0
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h0F);
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 8'hF0;
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 8'h00;
        @(negedge clk);
        #1;
        check("R11 latch kept", pin_out, 8'h0F);
        check("R11 dir kept", pin_oe, 8'hFF);
        bus_addr = 2'd0;
        #1 check("R11 idle rdata", bus_rdata, 8'h00);

        finish_run();
    end
endmodule